// File: doc/BRIEF.md
# Cascaded 16-bit Match-Clear Timer

This block is a 16-bit interval timer built from two 8-bit counter stages chained by a carry. While its run control is high it advances by one on every pulse of the selected prescaler tap. It compares the count with a 16-bit compare value held in two byte registers. When the count equals that value on a tick, the block raises a one-cycle interrupt request and returns the counter to zero. Counting then carries on without pausing.

The compare bytes are written through an 8-bit data port with separate low and high byte enables. There is no shadow copy, so a write changes the compare value from the next clock onward, even while the timer runs. Software writes the low byte first and then the high byte. The tick source is one of four prescaler taps. A divider select swaps the slowest tap for the slow-oscillator tap, and a low-power mode input forces the slow-oscillator tap whatever the source select says. The timer period is (N+1) source ticks for a compare value N. For example, a 62.5 kHz tap with N = 0x927C gives about 600 ms, and half that on a tap twice as fast.

Top module: `match_timer16`

## Requirements
- R1: After the asynchronous reset, `count_o` is 0 and `irq_o` is low.
- R2: With `slow_mode_i` low, `src_sel_i` chooses the tick source: 0 selects `tick_fc11_i` (or `tick_fs3_i` when `slow_div_i` is 1), 1 selects `tick_fc7_i`, 2 selects `tick_fc5_i` and 3 selects `tick_fc3_i`. Pulses on unselected tap inputs have no effect on `count_o`.
- R3: With `slow_mode_i` high, only `tick_fs3_i` advances the counter, whatever `src_sel_i` and `slow_div_i` are.
- R4: While `run_i` is high, each selected tick that is not a match raises `count_o` by one in the next cycle. Without a selected tick, `count_o` holds its value.
- R5: A selected tick arriving while `count_o` equals the compare value drives `irq_o` high in that same cycle, for one cycle only. The count is 0 in the next cycle. With compare value N, interrupts recur every N+1 ticks.
- R6: A compare value of 0 gives an interrupt on every selected tick, and the count stays 0.
- R7: `wr_lo_i` loads `wr_data_i` into compare bits 7:0 and `wr_hi_i` loads it into bits 15:8. The new value takes effect from the next cycle, even while the timer runs.
- R8: When a byte write and a selected tick occur in the same cycle, the tick is compared against the compare value from before the write.
- R9: While `run_i` is low, `count_o` is 0 from the next cycle on and ticks are ignored. After `run_i` rises again, counting restarts from 0.
- R10: The count carries from the low byte into the high byte, so the sequence runs 0x00FF, 0x0100 and upward across the full 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_lo_i | input | 1 | Write enable for the compare low byte |
| wr_hi_i | input | 1 | Write enable for the compare high byte |
| wr_data_i | input | 8 | Byte written to the compare register |
| run_i | input | 1 | Start/stop control; low clears the counter |
| src_sel_i | input | 2 | Tick source select |
| slow_div_i | input | 1 | Replaces the slowest fast tap with the slow-oscillator tap |
| slow_mode_i | input | 1 | Low-power mode; only the slow-oscillator tap is used |
| tick_fc3_i | input | 1 | Prescaler tap pulse, fastest |
| tick_fc5_i | input | 1 | Prescaler tap pulse |
| tick_fc7_i | input | 1 | Prescaler tap pulse |
| tick_fc11_i | input | 1 | Prescaler tap pulse, slowest fast tap |
| tick_fs3_i | input | 1 | Slow-oscillator tap pulse |
| irq_o | output | 1 | Interrupt request, one-cycle pulse on a match |
| count_o | output | 16 | Current counter value |

## Verification
The assertions assume that each tap pulse lasts one clock and that `run_i` changes only between ticks. They also assume no reset pulse shorter than a clock. The bench drives every input on the falling edge and holds each tap high for exactly one cycle, with idle cycles between ticks. It raises at most one tap at a time, except in the tap-isolation vectors, where the unselected tap is the only one pulsed. Writes and `run_i` changes are applied in their own cycles, except in the one test that deliberately combines a write with a tick.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int unsigned N_TAPS  = 5;
  // tap vector positions
  localparam int unsigned TAP_FC3  = 0;
  localparam int unsigned TAP_FC5  = 1;
  localparam int unsigned TAP_FC7  = 2;
  localparam int unsigned TAP_FC11 = 3;
  localparam int unsigned TAP_FS3  = 4;

  typedef enum logic [1:0] {
    SRC_SLOWEST = 2'd0,
    SRC_MID     = 2'd1,
    SRC_FAST    = 2'd2,
    SRC_FASTEST = 2'd3
  } src_sel_e;
endpackage

// File: rtl/mt_tap_sel.sv
module mt_tap_sel
  import mt_pkg::*;
(
  input  logic [1:0]        src_sel_i,
  input  logic              slow_div_i,
  input  logic              slow_mode_i,
  input  logic [N_TAPS-1:0] taps_i,
  output logic              tick_o
);
  src_sel_e sel;
  assign sel = src_sel_e'(src_sel_i);

  always_comb begin
    tick_o = 1'b0;
    if (slow_mode_i) begin
      tick_o = taps_i[TAP_FS3];
    end else begin
      unique case (sel)
        SRC_SLOWEST: tick_o = slow_div_i ? taps_i[TAP_FS3] : taps_i[TAP_FC11];
        SRC_MID:     tick_o = taps_i[TAP_FC7];
        SRC_FAST:    tick_o = taps_i[TAP_FC5];
        SRC_FASTEST: tick_o = taps_i[TAP_FC3];
        default:     tick_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/mt_byte_stage.sv
module mt_byte_stage #(
  parameter int unsigned STAGE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               inc_i,
  input  logic               wr_en_i,
  input  logic [STAGE_W-1:0] wr_data_i,
  output logic [STAGE_W-1:0] cnt_o,
  output logic               carry_o,
  output logic               eq_o
);
  logic [STAGE_W-1:0] cnt_q;
  logic [STAGE_W-1:0] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  // compare byte: no shadow, live from the next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cmp_q <= '1;
    else if (wr_en_i) cmp_q <= wr_data_i;
  end

  assign cnt_o   = cnt_q;
  assign carry_o = inc_i & (&cnt_q);
  assign eq_o    = (cnt_q == cmp_q);
endmodule

// File: rtl/match_timer16.sv
module match_timer16
  import mt_pkg::*;
#(
  parameter int unsigned STAGE_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_lo_i,
  input  logic                 wr_hi_i,
  input  logic [STAGE_W-1:0]   wr_data_i,
  input  logic                 run_i,
  input  logic [1:0]           src_sel_i,
  input  logic                 slow_div_i,
  input  logic                 slow_mode_i,
  input  logic                 tick_fc3_i,
  input  logic                 tick_fc5_i,
  input  logic                 tick_fc7_i,
  input  logic                 tick_fc11_i,
  input  logic                 tick_fs3_i,
  output logic                 irq_o,
  output logic [2*STAGE_W-1:0] count_o
);
  localparam int unsigned N_STAGES = 2;

  logic [N_TAPS-1:0]   taps;
  logic                tick_sel;
  logic                advance;
  logic                hit;
  logic                clr;
  logic [N_STAGES-1:0] wr_en;
  logic [N_STAGES-1:0] inc;
  logic [N_STAGES-1:0] carry;
  logic [N_STAGES-1:0] eq;

  always_comb begin
    taps           = '0;
    taps[TAP_FC3]  = tick_fc3_i;
    taps[TAP_FC5]  = tick_fc5_i;
    taps[TAP_FC7]  = tick_fc7_i;
    taps[TAP_FC11] = tick_fc11_i;
    taps[TAP_FS3]  = tick_fs3_i;
  end

  mt_tap_sel u_tap_sel (
    .src_sel_i   (src_sel_i),
    .slow_div_i  (slow_div_i),
    .slow_mode_i (slow_mode_i),
    .taps_i      (taps),
    .tick_o      (tick_sel)
  );

  assign wr_en   = {wr_hi_i, wr_lo_i};
  assign advance = run_i & tick_sel;
  assign hit     = advance & (&eq);
  assign clr     = ~run_i | hit;

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign inc[g] = advance;
    end else begin : g_chain
      assign inc[g] = carry[g-1];
    end

    mt_byte_stage #(.STAGE_W(STAGE_W)) u_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr),
      .inc_i     (inc[g]),
      .wr_en_i   (wr_en[g]),
      .wr_data_i (wr_data_i),
      .cnt_o     (count_o[g*STAGE_W +: STAGE_W]),
      .carry_o   (carry[g]),
      .eq_o      (eq[g])
    );
  end

  assign irq_o = hit;
endmodule

// File: rtl/match_timer16_chk.sv
module match_timer16_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             tick_i,
  input logic             irq_i,
  input logic [CNT_W-1:0] count_i
);
  // R9
  stop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> count_i == '0);

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !tick_i |=> $stable(count_i));

  // R4
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && tick_i && !irq_i |=> count_i == CNT_W'($past(count_i) + 1'b1));

  // R5
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> count_i == '0);

  // R5
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> run_i && tick_i);
endmodule

bind match_timer16 match_timer16_chk #(.CNT_W(2*STAGE_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_i),
  .tick_i  (tick_sel),
  .irq_i   (irq_o),
  .count_i (count_o)
);

// File: tb/tb_match_timer16.sv
`timescale 1ns/1ps
module tb_match_timer16;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_lo = 1'b0, wr_hi = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        run = 1'b0;
  logic [1:0]  sel = '0;
  logic        slow_div = 1'b0, slow_mode = 1'b0;
  logic [4:0]  tick_v = '0; // 0 fc3, 1 fc5, 2 fc7, 3 fc11, 4 fs3
  logic        irq;
  logic [15:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  match_timer16 dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wr_data_i(wr_data),
    .run_i(run), .src_sel_i(sel), .slow_div_i(slow_div), .slow_mode_i(slow_mode),
    .tick_fc3_i(tick_v[0]), .tick_fc5_i(tick_v[1]), .tick_fc7_i(tick_v[2]),
    .tick_fc11_i(tick_v[3]), .tick_fs3_i(tick_v[4]),
    .irq_o(irq), .count_o(count)
  );

  // fields: [7:6] sel, [5] slow_div, [4] slow_mode, [3:1] tap pulsed, [0] expect advance
  localparam int N_VEC = 12;
  localparam logic [7:0] VEC [N_VEC] = '{
    8'h07, 8'h08, 8'h29, 8'h26, 8'h45, 8'h40,
    8'h83, 8'hC1, 8'hC2, 8'hD9, 8'hD0, 8'h54
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_once(input int tap, output logic irq_seen);
    @(negedge clk);
    tick_v = 5'(1 << tap);
    #1 irq_seen = irq;
    @(negedge clk);
    tick_v = '0;
  endtask

  task automatic write_cmp(input logic [15:0] v);
    @(negedge clk); wr_lo = 1'b1; wr_data = v[7:0];
    @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1; wr_data = v[15:8];
    @(negedge clk); wr_hi = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); run = 1'b0;
    @(negedge clk); run = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic s;
    int irqs;
    logic [15:0] c0;

    #7;
    // R1 reset state
    check(count == 16'h0 && irq == 1'b0, "R1", int'(count), 0);
    @(negedge clk); rst_n = 1'b1;
    write_cmp(16'hFFFF);
    @(negedge clk); run = 1'b1;

    // R2 / R3 tap selection table
    for (int i = 0; i < N_VEC; i++) begin
      @(negedge clk);
      sel = VEC[i][7:6]; slow_div = VEC[i][5]; slow_mode = VEC[i][4];
      c0 = count;
      tick_once(int'(VEC[i][3:1]), s);
      check(count == c0 + 16'(VEC[i][0]), VEC[i][4] ? "R3" : "R2",
            int'(count), int'(c0 + 16'(VEC[i][0])));
    end
    slow_mode = 1'b0; slow_div = 1'b0; sel = 2'd3;

    // R5 period with N = 3
    write_cmp(16'h0003);
    restart();
    irqs = 0;
    for (int k = 1; k <= 4; k++) begin
      tick_once(0, s);
      if (s) irqs++;
      if (k < 4) check(count == 16'(k) && !s, "R4", int'(count), k);
    end
    check(irqs == 1 && s && count == 16'h0, "R5", int'(count), 0);
    tick_once(0, s);
    check(count == 16'h1 && !s, "R5", int'(count), 1);

    // R6 compare zero
    write_cmp(16'h0000);
    restart();
    irqs = 0;
    for (int k = 0; k < 3; k++) begin
      tick_once(0, s);
      if (s) irqs++;
    end
    check(irqs == 3 && count == 16'h0, "R6", irqs, 3);

    // R10 carry, N = 0x0102
    write_cmp(16'h0102);
    restart();
    irqs = 0;
    for (int k = 0; k < 256; k++) begin
      tick_once(0, s);
      if (s) irqs++;
    end
    check(count == 16'h0100 && irqs == 0, "R10", int'(count), 16'h0100);
    tick_once(0, s); tick_once(0, s);
    check(count == 16'h0102 && !s, "R10", int'(count), 16'h0102);
    tick_once(0, s);
    check(s && count == 16'h0, "R7", int'(count), 0);

    // R7 immediate low-byte write while running
    write_cmp(16'h0010);
    restart();
    for (int k = 0; k < 5; k++) tick_once(0, s);
    @(negedge clk); wr_lo = 1'b1; wr_data = 8'h05;
    @(negedge clk); wr_lo = 1'b0;
    tick_once(0, s);
    check(s && count == 16'h0, "R7", int'(s), 1);

    // R8 write and tick in the same cycle use the old value
    write_cmp(16'h0010);
    restart();
    tick_once(0, s); tick_once(0, s);
    @(negedge clk); wr_lo = 1'b1; wr_data = 8'h02; tick_v = 5'b00001;
    #1 s = irq;
    @(negedge clk); wr_lo = 1'b0; tick_v = '0;
    check(!s && count == 16'h3, "R8", int'(count), 3);

    // R9 stop clears and ignores ticks, restart from 0
    write_cmp(16'hFFFF);
    for (int k = 0; k < 3; k++) tick_once(0, s);
    @(negedge clk); run = 1'b0;
    @(negedge clk);
    check(count == 16'h0, "R9", int'(count), 0);
    tick_once(0, s);
    check(count == 16'h0 && !s, "R9", int'(count), 0);
    @(negedge clk); run = 1'b1;
    tick_once(0, s);
    check(count == 16'h1, "R9", int'(count), 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule